// File: doc/BRIEF.md
# Segment Address Extension and Protection Unit

This block sits between one processor core and the system interconnect. It takes 32-bit logical addresses from the core and turns them into 36-bit physical addresses. It uses a table of sixteen programmable 64-bit segment descriptors. Each descriptor names a naturally aligned logical window, the physical window that replaces it, and six access rights. The rights are read, write and execute, given separately for user and supervisor requests. A request that hits no enabled segment is answered with a fault. So is a request that the winning segment does not permit. In both cases the unit echoes the logical address and privilege of the request so that the fault can be traced.

Every core gets its own instance, so the tables are independent. Software loads descriptors through a simple write port and reads them back through a combinational read port. Requests enter through a valid/ready handshake and leave one clock later through a second valid/ready handshake. The response stage holds its contents while the consumer stalls.

Top module: `sxu_top`

## Requirements
- R1: After reset the response side is idle (rsp_valid 0, req_ready 1), every descriptor reads back as zero, and every request therefore faults as a miss.
- R2: A write on the configuration port stores the 64-bit word at the given index, and the read port returns the stored word unchanged, reserved bits included.
- R3: Descriptor fields are: size code in bits [4:0], rights in bits [10:5], physical base address bits [35:12] in bits [35:12], and logical base address bits [31:12] in bits [63:44]. On a hit, the physical address keeps the segment's offset bits from the logical address and takes all higher bits from the physical base.
- R4: A size code n covers 2^(n+1) bytes. Codes 1 to 10 all give a 4 KB window, code 31 covers the full 4 GB, and code 0 disables the segment.
- R5: When several enabled segments contain the address, the highest-numbered one supplies the translation and the rights.
- R6: A request that hits no enabled segment responds with fault code 1 and physical address zero. It echoes the logical address on rsp_laddr and the privilege on rsp_sup.
- R7: The rights bits are: bit 0 user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write, bit 5 supervisor execute. Access kinds are 0 read, 1 write, 2 execute; kind 3 is never permitted. A denied access responds with fault code 2 and physical address zero.
- R8: A request accepted at a clock edge appears on the response port after that edge. While rsp_valid is high and rsp_ready is low, the response stays unchanged and req_ready is low.
- R9: A request accepted on the same edge as a descriptor write sees the old table contents. Requests accepted afterwards see the new contents.
- R10: Two descriptors can map logical 0x8000_0000–0xFFFF_FFFF onto physical 0x8_0000_0000–0x8_7FFF_FFFF while the low half stays at physical 0x0_xxxx_xxxx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_widx | input | 4 | Descriptor index to write |
| cfg_wdata | input | 64 | Descriptor word to write |
| cfg_ridx | input | 4 | Descriptor index to read |
| cfg_rdata | output | 64 | Descriptor word at cfg_ridx |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_laddr | input | 32 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_sup | input | 1 | 1 = supervisor request, 0 = user |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 36 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 rights violation |
| rsp_laddr | output | 32 | Logical address of the answered request |
| rsp_sup | output | 1 | Privilege of the answered request |

## Verification
On every cycle the embedded properties check four things. A write lands in the indexed descriptor. The response appears one edge after acceptance and holds under backpressure. A faulted response never carries a physical address. A clean response keeps the page offset of its logical address. The exact substituted high bits, the size-code decoding with its 4 KB floor, the choice among overlapping segments, the rights matrix and the ordering of a write against a request on the same edge all depend on table contents. Only the directed scenarios show these, by comparing response words with values worked out by hand.

// File: rtl/sxu_pkg.sv
`timescale 1ns/1ps
package sxu_pkg;
   localparam int LA_W    = 32;
   localparam int PA_W    = 36;
   localparam int PG_W    = 12;
   localparam int SZ_W    = 5;
   localparam int PERM_W  = 6;
   localparam int DESC_W  = 64;
   localparam int LB_W    = LA_W - PG_W;
   localparam int PB_W    = PA_W - PG_W;
   localparam int SZ_LO   = 0;
   localparam int PERM_LO = SZ_LO + SZ_W;
   localparam int PB_LO   = PG_W;
   localparam int LB_LO   = DESC_W - LB_W;

   localparam logic [1:0] FLT_NONE = 2'd0;
   localparam logic [1:0] FLT_MISS = 2'd1;
   localparam logic [1:0] FLT_PERM = 2'd2;
   localparam logic [1:0] ACC_BAD  = 2'd3;

   typedef struct packed {
      logic [LB_W-1:0]   lbase;
      logic [PB_W-1:0]   pbase;
      logic [PERM_W-1:0] perm;
      logic [SZ_W-1:0]   size;
   } seg_t;

   function automatic seg_t desc_unpack(input logic [DESC_W-1:0] w);
      seg_t s;
      s.size  = w[SZ_LO +: SZ_W];
      s.perm  = w[PERM_LO +: PERM_W];
      s.pbase = w[PB_LO +: PB_W];
      s.lbase = w[LB_LO +: LB_W];
      return s;
   endfunction

   // Offset-bit mask of a segment: 2^(code+1) bytes, never below one page.
   function automatic logic [LA_W-1:0] span_mask(input logic [SZ_W-1:0] code);
      logic [LA_W-1:0] m;
      int n;
      n = (int'(code) < PG_W - 1) ? PG_W : int'(code) + 1;
      for (int b = 0; b < LA_W; b++) m[b] = (b < n);
      return m;
   endfunction
endpackage

// File: rtl/sxu_regs.sv
`timescale 1ns/1ps
module sxu_regs
   import sxu_pkg::*;
#(
   parameter int NSEG  = 16,
   parameter int IDX_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      widx,
   input  logic [DESC_W-1:0]     wdata,
   input  logic [IDX_W-1:0]      ridx,
   output logic [DESC_W-1:0]     rdata,
   output seg_t [NSEG-1:0]       segs
);
   logic [DESC_W-1:0] mem_q [NSEG];

   for (genvar i = 0; i < NSEG; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                                 mem_q[i] <= '0;
         else if (we && (int'(widx) == i))          mem_q[i] <= wdata;
      end
      assign segs[i] = desc_unpack(mem_q[i]);
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NSEG; i++)
         if (int'(ridx) == i) rdata = mem_q[i];
   end

   // R2: a written word is present in the addressed entry one edge later
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(widx) < NSEG) |=> (mem_q[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/sxu_match.sv
`timescale 1ns/1ps
module sxu_match
   import sxu_pkg::*;
#(
   parameter int NSEG = 16
) (
   input  logic [LA_W-1:0]             la,
   input  seg_t [NSEG-1:0]             segs,
   output logic [NSEG-1:0]             hit,
   output logic [NSEG-1:0][PA_W-1:0]   pa
);
   localparam int XW = PA_W - LA_W;

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      logic [LA_W-1:0] lmask;
      logic [PA_W-1:0] pmask;
      logic [LA_W-1:0] lbase_full;
      logic [PA_W-1:0] pbase_full;
      assign lmask      = span_mask(segs[i].size);
      assign pmask      = {{XW{1'b0}}, lmask};
      assign lbase_full = {segs[i].lbase, {PG_W{1'b0}}};
      assign pbase_full = {segs[i].pbase, {PG_W{1'b0}}};
      assign hit[i] = (segs[i].size != '0) && (((la ^ lbase_full) & ~lmask) == '0);
      assign pa[i]  = (pbase_full & ~pmask) | ({{XW{1'b0}}, la} & pmask);
   end
endmodule

// File: rtl/sxu_select.sv
`timescale 1ns/1ps
module sxu_select
   import sxu_pkg::*;
#(
   parameter int NSEG      = 16,
   parameter bit PRIO_HIGH = 1'b1
) (
   input  logic [NSEG-1:0]             hit,
   input  logic [NSEG-1:0][PA_W-1:0]   pa,
   input  seg_t [NSEG-1:0]             segs,
   output logic                        any_hit,
   output logic [PA_W-1:0]             win_pa,
   output logic [PERM_W-1:0]           win_perm
);
   assign any_hit = |hit;

   if (PRIO_HIGH) begin : g_high
      // later iterations override: highest index wins
      always_comb begin
         win_pa = '0; win_perm = '0;
         for (int i = 0; i < NSEG; i++)
            if (hit[i]) begin win_pa = pa[i]; win_perm = segs[i].perm; end
      end
   end else begin : g_low
      always_comb begin
         win_pa = '0; win_perm = '0;
         for (int i = NSEG - 1; i >= 0; i--)
            if (hit[i]) begin win_pa = pa[i]; win_perm = segs[i].perm; end
      end
   end
endmodule

// File: rtl/sxu_top.sv
`timescale 1ns/1ps
module sxu_top
   import sxu_pkg::*;
#(
   parameter int  NSEG      = 16,
   parameter bit  PRIO_HIGH = 1'b1,
   localparam int IDX_W     = (NSEG > 1) ? $clog2(NSEG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_widx,
   input  logic [63:0]          cfg_wdata,
   input  logic [IDX_W-1:0]     cfg_ridx,
   output logic [63:0]          cfg_rdata,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [31:0]          req_laddr,
   input  logic [1:0]           req_kind,
   input  logic                 req_sup,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [35:0]          rsp_paddr,
   output logic [1:0]           rsp_fault,
   output logic [31:0]          rsp_laddr,
   output logic                 rsp_sup
);
   // elaboration-time parameter checks
   if (NSEG < 1 || NSEG > (1 << IDX_W)) begin : g_bad_nseg
      $error("sxu_top: NSEG out of range");
   end
   if (PA_W < LA_W || DESC_W != 64 || LA_W != 32 || PA_W != 36) begin : g_bad_width
      $error("sxu_top: address widths inconsistent with ports");
   end
   if (PERM_LO + PERM_W > PB_LO || PB_LO + PB_W > LB_LO) begin : g_bad_layout
      $error("sxu_top: descriptor fields overlap");
   end
   if ((1 << SZ_W) < LA_W) begin : g_bad_size
      $error("sxu_top: size code cannot reach full span");
   end

   seg_t [NSEG-1:0]            segs;
   logic [NSEG-1:0]            hit;
   logic [NSEG-1:0][PA_W-1:0]  seg_pa;
   logic                       any_hit;
   logic [PA_W-1:0]            win_pa;
   logic [PERM_W-1:0]          win_perm;

   sxu_regs #(.NSEG(NSEG), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_widx), .wdata(cfg_wdata),
      .ridx(cfg_ridx), .rdata(cfg_rdata), .segs(segs));

   sxu_match #(.NSEG(NSEG)) u_match (
      .la(req_laddr), .segs(segs), .hit(hit), .pa(seg_pa));

   sxu_select #(.NSEG(NSEG), .PRIO_HIGH(PRIO_HIGH)) u_sel (
      .hit(hit), .pa(seg_pa), .segs(segs),
      .any_hit(any_hit), .win_pa(win_pa), .win_perm(win_perm));

   // rights lookup: index = 3*privilege + kind
   logic [2:0] pidx;
   logic [7:0] perm_ext;
   logic       perm_ok;
   logic [1:0] flt_d;
   assign pidx     = (req_sup ? 3'd3 : 3'd0) + {1'b0, req_kind};
   assign perm_ext = {{(8-PERM_W){1'b0}}, win_perm};
   assign perm_ok  = (req_kind != ACC_BAD) && perm_ext[pidx];
   assign flt_d    = !any_hit ? FLT_MISS : (!perm_ok ? FLT_PERM : FLT_NONE);

   logic              vld_q;
   logic [PA_W-1:0]   pa_q;
   logic [1:0]        flt_q;
   logic [LA_W-1:0]   la_q;
   logic              sup_q;

   assign req_ready = !vld_q || rsp_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pa_q  <= '0;
         flt_q <= FLT_NONE;
         la_q  <= '0;
         sup_q <= 1'b0;
      end else if (req_ready) begin
         vld_q <= req_valid;
         if (req_valid) begin
            pa_q  <= (flt_d == FLT_NONE) ? win_pa : '0;
            flt_q <= flt_d;
            la_q  <= req_laddr;
            sup_q <= req_sup;
         end
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_paddr = pa_q;
   assign rsp_fault = flt_q;
   assign rsp_laddr = la_q;
   assign rsp_sup   = sup_q;

   // R8: accepted request is answered on the next edge
   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   // R8: a stalled response keeps its contents
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                     && $stable(rsp_fault) && $stable(rsp_laddr)));
   // R8: no acceptance while the response is stalled
   p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);
   // R6 / R7: a faulted request never carries a physical address
   p_fault_unforwarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
   // R3: a clean translation preserves the page offset
   p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[PG_W-1:0] == rsp_laddr[PG_W-1:0]));
endmodule

// File: tb/test_sxu_top.sv
`timescale 1ns/1ps
module test_sxu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_widx = '0;
   logic [63:0] cfg_wdata = '0;
   logic [3:0]  cfg_ridx = '0;
   logic [63:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_sup = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [35:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic [31:0] rsp_laddr;
   logic        rsp_sup;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sxu_top i_sxu_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
      .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
      .req_kind(req_kind), .req_sup(req_sup), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .rsp_laddr(rsp_laddr), .rsp_sup(rsp_sup));

   function automatic logic [63:0] mk(input logic [31:0] lb, input logic [35:0] pb,
                                      input logic [5:0] perm, input logic [4:0] sz);
      return {lb[31:12], 8'h00, pb[35:12], 1'b0, perm, sz};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic put_seg(input int idx, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_widx = 4'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic xlate(input string tag, input logic [31:0] a, input logic [1:0] k,
                        input logic s, input logic [35:0] exp_pa, input logic [1:0] exp_f);
      @(negedge clk);
      rsp_ready = 1'b1; req_valid = 1'b1; req_laddr = a; req_kind = k; req_sup = s;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
      chk({tag, " fault"}, 64'(rsp_fault), 64'(exp_f));
      chk({tag, " laddr"}, 64'(rsp_laddr), 64'(a));
      chk({tag, " sup"},   64'(rsp_sup),   64'(s));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
      chk("R1 req_ready", 64'(req_ready), 64'd1);
      cfg_ridx = 4'd0;  #0.1 chk("R1 desc0 zero", cfg_rdata, 64'd0);
      cfg_ridx = 4'd15; #0.1 chk("R1 desc15 zero", cfg_rdata, 64'd0);
      xlate("R1 R6 miss user", 32'h0000_1234, 2'd0, 1'b0, 36'h0, 2'd1);
      xlate("R6 miss sup", 32'hCAFE_0008, 2'd2, 1'b1, 36'h0, 2'd1);
   endtask

   task automatic t_split;
      put_seg(0, mk(32'h0000_0000, 36'h0_0000_0000, 6'h3F, 5'd30));
      put_seg(1, mk(32'h8000_0000, 36'h8_0000_0000, 6'h3F, 5'd30));
      cfg_ridx = 4'd1; #0.1 chk("R2 readback desc1", cfg_rdata,
                                mk(32'h8000_0000, 36'h8_0000_0000, 6'h3F, 5'd30));
      put_seg(14, 64'hFFFF_FFFF_FFFF_FFE0);
      cfg_ridx = 4'd14; #0.1 chk("R2 readback raw", cfg_rdata, 64'hFFFF_FFFF_FFFF_FFE0);
      xlate("R10 high start", 32'h8000_1234, 2'd0, 1'b0, 36'h8_0000_1234, 2'd0);
      xlate("R10 high end",   32'hFFFF_FFFC, 2'd1, 1'b1, 36'h8_7FFF_FFFC, 2'd0);
      xlate("R10 R3 low",     32'h0C00_0010, 2'd2, 1'b0, 36'h0_0C00_0010, 2'd0);
   endtask

   task automatic t_prio;
      put_seg(3, mk(32'h0C00_0000, 36'h2_0000_0000, 6'h3F, 5'd11));
      put_seg(5, mk(32'h0C00_0000, 36'h1_2340_0000, 6'h3F, 5'd15));
      xlate("R5 highest wins",  32'h0C00_0ABC, 2'd0, 1'b1, 36'h1_2340_0ABC, 2'd0);
      xlate("R5 R3 64K window", 32'h0C00_ABCD, 2'd0, 1'b1, 36'h1_2340_ABCD, 2'd0);
      xlate("R5 outside falls", 32'h0C01_0000, 2'd0, 1'b1, 36'h0_0C01_0000, 2'd0);
   endtask

   task automatic t_size;
      put_seg(7, mk(32'h2000_0000, 36'h3_0000_5000, 6'h3F, 5'd3));
      xlate("R4 small code 4K top", 32'h2000_0FFF, 2'd0, 1'b0, 36'h3_0000_5FFF, 2'd0);
      xlate("R4 past 4K",           32'h2000_1000, 2'd0, 1'b0, 36'h0_2000_1000, 2'd0);
      put_seg(15, mk(32'h0000_0000, 36'hA_0000_0000, 6'h3F, 5'd31));
      xlate("R4 code 31 full", 32'h9000_0000, 2'd0, 1'b0, 36'hA_9000_0000, 2'd0);
      put_seg(15, 64'd0);
      put_seg(7, mk(32'h2000_0000, 36'h3_0000_5000, 6'h3F, 5'd0));
      xlate("R4 code 0 disabled", 32'h2000_0FFF, 2'd0, 1'b0, 36'h0_2000_0FFF, 2'd0);
   endtask

   task automatic t_perm;
      put_seg(9, mk(32'h4000_0000, 36'h4_4000_0000, 6'h19, 5'd11));
      xlate("R7 user read ok",   32'h4000_0123, 2'd0, 1'b0, 36'h4_4000_0123, 2'd0);
      xlate("R7 user write deny", 32'h4000_0123, 2'd1, 1'b0, 36'h0, 2'd2);
      xlate("R7 user exec deny", 32'h4000_0123, 2'd2, 1'b0, 36'h0, 2'd2);
      xlate("R7 sup write ok",   32'h4000_0456, 2'd1, 1'b1, 36'h4_4000_0456, 2'd0);
      xlate("R7 sup exec deny",  32'h4000_0456, 2'd2, 1'b1, 36'h0, 2'd2);
      xlate("R7 kind 3 deny",    32'h4000_0456, 2'd3, 1'b1, 36'h0, 2'd2);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      cfg_we = 1'b1; cfg_widx = 4'd12;
      cfg_wdata = mk(32'hF000_0000, 36'h5_0000_0000, 6'h3F, 5'd11);
      rsp_ready = 1'b1; req_valid = 1'b1; req_laddr = 32'hF000_0010;
      req_kind = 2'd0; req_sup = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk("R9 same edge old table", 64'(rsp_paddr), 64'h8_7000_0010);
      xlate("R9 later new table", 32'hF000_0010, 2'd0, 1'b1, 36'h5_0000_0010, 2'd0);
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_laddr = 32'h0000_1000;
      req_kind = 2'd0; req_sup = 1'b0;
      @(negedge clk);
      req_laddr = 32'h8000_0040;
      chk("R8 one cycle valid", 64'(rsp_valid), 64'd1);
      chk("R8 stall blocks", 64'(req_ready), 64'd0);
      chk("R8 first paddr", 64'(rsp_paddr), 64'h0_0000_1000);
      @(negedge clk);
      chk("R8 held paddr", 64'(rsp_paddr), 64'h0_0000_1000);
      chk("R8 still blocked", 64'(req_ready), 64'd0);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 second valid", 64'(rsp_valid), 64'd1);
      chk("R8 second paddr", 64'(rsp_paddr), 64'h8_0000_0040);
      @(negedge clk);
      chk("R8 drained", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_split;
      t_prio;
      t_size;
      t_perm;
      t_same_cycle;
      t_backpressure;
      report;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      report;
      $finish;
   end
endmodule